// File: doc/BRIEF.md
# Oversampled SPI Command Frame Receiver

This block is the serial front end of a multi-channel switch controller. A host sends a 16-bit frame over a four-wire SPI link: first an 8-bit control byte, then an 8-bit data byte. At the same time the block returns a 16-bit diagnostic word on its serial output. The block runs entirely from a fast system clock. The SCLK, SI and chip-select pins are treated as slow asynchronous inputs. Each one is synchronized, and its edges are found in the system clock domain.

The diagnostic word is captured in parallel when chip-select falls. When chip-select rises, the block accepts the data byte only if two conditions hold. The frame must have had exactly sixteen SCLK pulses, and the control byte must not be the "read diagnostics only" code 00h. An accepted data byte leaves the block as a one-cycle strobe with an 8-bit bus that holds its value. Every rising edge of chip-select also sends a one-cycle clear pulse to the diagnostic source, whether or not the data byte was accepted.

Top module: `spi_frame_rx`

## Requirements
- R1: While rst_n is low and after its release, so_oe, so_data, commit_stb and diag_clear are 0 and commit_data is 00h. No commit follows until a complete frame arrives.
- R2: While the synchronized chip-select is high, so_oe is 0 and so_data is 0. While it is low, so_oe is 1.
- R3: On the falling edge of chip-select, diag_word is loaded in parallel. diag_word bit 15 is on so_data before the first SCLK rising edge.
- R4: so_data changes only on SCLK rising edges and sends the word MSB first. The value sampled before the k-th SCLK falling edge (k = 1..16) is diag_word bit 16-k.
- R5: SI is sampled on SCLK falling edges, MSB first. The first 8 bits received form the control byte (frame bits 15:8). The last 8 form the data byte (frame bits 7:0).
- R6: A frame is accepted only if exactly 16 SCLK falling edges occur while chip-select is low. A frame with 15 or 17 pulses produces no commit_stb.
- R7: A control byte of 00h means diagnostics only: there is no commit_stb and commit_data is unchanged. Any other control value, FFh and 95h included, commits the data byte.
- R8: A commit is a single-cycle commit_stb. commit_data takes the new data byte in that same cycle and keeps it until the next commit.
- R9: Every chip-select rising edge produces exactly one single-cycle diag_clear pulse, whether or not the frame is accepted.
- R10: The pulse counter saturates above 16, so a frame of 48 pulses (48 mod 32 = 16) is rejected.
- R11: SCLK and SI activity while chip-select is high has no effect. It produces no commit_stb and no diag_clear, and so_oe stays 0.
- R12: Asserting rst_n in the middle of a frame abandons that frame. After reset, the remainder of the frame and the chip-select rise produce no commit_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_pin | input | 1 | Serial clock pin (asynchronous) |
| si_pin | input | 1 | Serial data in pin (asynchronous) |
| cs_n_pin | input | 1 | Active-low chip-select pin (asynchronous) |
| diag_word | input | 16 | Diagnostic word captured at chip-select fall |
| so_data | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the serial data out pad |
| commit_stb | output | 1 | One-cycle strobe: a data byte was accepted |
| commit_data | output | 8 | Most recently accepted data byte |
| diag_clear | output | 1 | One-cycle clear pulse to the diagnostic source |

## Verification
Two situations are the hardest to reach from the ports. The first is an overlong frame whose pulse count would wrap back to exactly sixteen in a 5-bit counter. The bench reaches it by sending a 48-pulse frame with a valid control byte and checking that nothing is committed. The second is a reset that arrives while chip-select is held low in mid-frame. The bench pulses rst_n after ten SCLK pulses, completes the frame, and checks that no commit follows. The same stimulus covers the spurious chip-select fall seen after reset, because the synchronizers restart in the idle state.

// File: rtl/spi_frame_pkg.sv
// Package: shared sizes and codes for the SPI command frame receiver.
// Assumes a frame is a control field followed by a data field.
package spi_frame_pkg;
    localparam int FRAME_W = 16;
    localparam int CTRL_W  = 8;
    localparam int SYNC_N  = 2;
    localparam logic [CTRL_W-1:0] DIAG_ONLY_CODE = '0;
endpackage

// File: rtl/spi_pin_sync.sv
// spi_pin_sync: multi-stage synchronizer for a vector of asynchronous pins.
// Assumes that every bit is an independent, slowly changing level. The
// reset value sets the idle level of each pin.
module spi_pin_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_in,
    output logic [WIDTH-1:0] level
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Purpose: capture the raw pins into the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= RST_VAL;
                else        stg[0] <= pins_in;
            end
        end else begin : g_next
            // Purpose: pass the value on to the next stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign level = stg[STAGES-1];
endmodule

// File: rtl/spi_edge_det.sv
// spi_edge_det: finds rising and falling edges of a synchronized level.
// Assumes that the input is already in the clk domain. The reset value
// matches the idle level, so release from reset creates no false edge.
module spi_edge_det #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);
    logic prev;

    // Purpose: remember the level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= level;
    end

    assign rise = level & ~prev;
    assign fall = ~level & prev;
endmodule

// File: rtl/spi_bit_counter.sv
// spi_bit_counter: counts serial clock pulses within a frame. It saturates
// at LIMIT+1, so an overlong frame cannot wrap back to LIMIT.
// Assumes that clear and inc never need to act in the same cycle.
module spi_bit_counter #(
    parameter int LIMIT = 16,
    parameter int CNT_W = $clog2(LIMIT + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             exact
);
    localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(LIMIT + 1);
    localparam logic [CNT_W-1:0] HIT_VAL = CNT_W'(LIMIT);

    // Purpose: clear at frame start and count up to the saturation point.
    always_ff @(posedge clk) begin
        if (!rst_n)                          count <= '0;
        else if (clear)                      count <= '0;
        else if (inc && (count != SAT_VAL))  count <= count + 1'b1;
    end

    assign exact = (count == HIT_VAL);
endmodule

// File: rtl/spi_shift_core.sv
// spi_shift_core: one shared shift register. It is loaded in parallel with
// the outgoing word and fills from SI as the outgoing bits leave. A separate
// output flop presents the MSB and updates on the launch strobe only.
// Assumes that load, shift and step are single-cycle strobes.
module spi_shift_core #(
    parameter int BITS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [BITS-1:0] load_val,
    input  logic            shift,
    input  logic            shift_in,
    input  logic            step,
    output logic [BITS-1:0] word,
    output logic            out_bit
);
    // Purpose: parallel load at frame start, shift left on each sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     word <= '0;
        else if (load)  word <= load_val;
        else if (shift) word <= {word[BITS-2:0], shift_in};
    end

    // Purpose: present the current MSB, updated on load or launch strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)     out_bit <= 1'b0;
        else if (load)  out_bit <= load_val[BITS-1];
        else if (step)  out_bit <= word[BITS-1];
    end
endmodule

// File: rtl/spi_frame_rx.sv
// spi_frame_rx: oversampled SPI slave for a control+data command frame.
// Assumes that clk is several times faster than SCLK and that SCLK is low
// whenever chip-select changes. Pins are synchronized inside the block.
module spi_frame_rx #(
    parameter int FRAME_W = spi_frame_pkg::FRAME_W,
    parameter int CTRL_W  = spi_frame_pkg::CTRL_W,
    parameter int SYNC_N  = spi_frame_pkg::SYNC_N,
    parameter logic [CTRL_W-1:0] DIAG_ONLY_CODE = spi_frame_pkg::DIAG_ONLY_CODE
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sclk_pin,
    input  logic                       si_pin,
    input  logic                       cs_n_pin,
    input  logic [FRAME_W-1:0]         diag_word,
    output logic                       so_data,
    output logic                       so_oe,
    output logic                       commit_stb,
    output logic [FRAME_W-CTRL_W-1:0]  commit_data,
    output logic                       diag_clear
);
    localparam int DATA_W = FRAME_W - CTRL_W;
    localparam int CNT_W  = $clog2(FRAME_W + 2);

    logic [2:0]         pin_lvl;
    logic               sclk_lvl, si_lvl, cs_lvl;
    logic               sclk_rise, sclk_fall, cs_rise, cs_fall;
    logic               selected;
    logic [CNT_W-1:0]   bit_cnt;
    logic               cnt_exact;
    logic [FRAME_W-1:0] frame;
    logic               out_bit;
    logic               accept;

    spi_pin_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_N),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_in ({cs_n_pin, si_pin, sclk_pin}),
        .level   (pin_lvl)
    );

    assign sclk_lvl = pin_lvl[0];
    assign si_lvl   = pin_lvl[1];
    assign cs_lvl   = pin_lvl[2];
    assign selected = ~cs_lvl;

    spi_edge_det #(.RST_VAL(1'b0)) u_sclk_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sclk_lvl),
        .rise  (sclk_rise),
        .fall  (sclk_fall)
    );

    spi_edge_det #(.RST_VAL(1'b1)) u_cs_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (cs_lvl),
        .rise  (cs_rise),
        .fall  (cs_fall)
    );

    spi_bit_counter #(.LIMIT(FRAME_W), .CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cs_fall),
        .inc   (sclk_fall & selected),
        .count (bit_cnt),
        .exact (cnt_exact)
    );

    spi_shift_core #(.BITS(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cs_fall),
        .load_val (diag_word),
        .shift    (sclk_fall & selected),
        .shift_in (si_lvl),
        .step     (sclk_rise & selected),
        .word     (frame),
        .out_bit  (out_bit)
    );

    assign accept = cs_rise && cnt_exact
                    && (frame[FRAME_W-1 -: CTRL_W] != DIAG_ONLY_CODE);

    // Purpose: issue the commit strobe, hold the data byte, pulse the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_stb  <= 1'b0;
            commit_data <= '0;
            diag_clear  <= 1'b0;
        end else begin
            commit_stb <= accept;
            diag_clear <= cs_rise;
            if (accept) commit_data <= frame[DATA_W-1:0];
        end
    end

    assign so_oe   = selected;
    assign so_data = selected & out_bit;
endmodule

// File: rtl/spi_frame_rx_chk.sv
// spi_frame_rx_chk: temporal checks on the frame receiver, bound to the top.
// Assumes a synchronous active-low reset. All properties are off in reset.
module spi_frame_rx_chk #(
    parameter int FRAME_W = 16,
    parameter int DATA_W  = 8,
    parameter int CNT_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              so_oe,
    input logic              commit_stb,
    input logic [DATA_W-1:0] commit_data,
    input logic              diag_clear,
    input logic [CNT_W-1:0]  bit_cnt
);
    p_stb_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |=> !commit_stb);

    p_data_moves_on_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_data != $past(commit_data)) |-> commit_stb);

    p_commit_needs_full_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |-> ($past(bit_cnt) == CNT_W'(FRAME_W)));

    p_commit_with_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |-> diag_clear);

    p_clear_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        diag_clear |=> !diag_clear);

    p_clear_when_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        diag_clear |-> !so_oe);

    p_count_saturates_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_W + 1));
endmodule

bind spi_frame_rx spi_frame_rx_chk #(
    .FRAME_W (FRAME_W),
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .so_oe       (so_oe),
    .commit_stb  (commit_stb),
    .commit_data (commit_data),
    .diag_clear  (diag_clear),
    .bit_cnt     (bit_cnt)
);

// File: tb/spi_frame_rx_test.sv
module spi_frame_rx_test;
    localparam int H = 4;   // system clocks per SCLK half period
    localparam int NV = 8;
    // vector fields: diag[37:22] frame[21:6] pulses[5:0]
    localparam logic [37:0] VEC [NV] = '{
        {16'hA5C3, 16'hFF3C, 6'd16},
        {16'h0F0F, 16'h0055, 6'd16},
        {16'hFFFF, 16'h95AA, 6'd16},
        {16'h1234, 16'hFF00, 6'd15},
        {16'h8001, 16'hFF7E, 6'd17},
        {16'h0000, 16'h01FF, 6'd16},
        {16'h5A5A, 16'hFFC3, 6'd48},
        {16'hC0DE, 16'h00FF, 6'd16}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_pin = 1'b0, si_pin = 1'b0, cs_n_pin = 1'b1;
    logic [15:0] diag_word = '0;
    logic so_data, so_oe, commit_stb, diag_clear;
    logic [7:0] commit_data;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [7:0] exp_data = 8'h00;

    always #5 clk = ~clk;

    spi_frame_rx uut (
        .clk(clk), .rst_n(rst_n), .sclk_pin(sclk_pin), .si_pin(si_pin),
        .cs_n_pin(cs_n_pin), .diag_word(diag_word), .so_data(so_data),
        .so_oe(so_oe), .commit_stb(commit_stb), .commit_data(commit_data),
        .diag_clear(diag_clear)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Ends the frame and checks strobe and clear counts and the held data byte.
    task automatic close_frame(input bit exp_commit, input string tag);
        int n_stb = 0;
        int n_clr = 0;
        cs_n_pin = 1'b1;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (commit_stb) n_stb++;
            if (diag_clear) n_clr++;
        end
        chk(n_stb == int'(exp_commit), {tag, " R6/R7 commit count"}, n_stb, exp_commit);
        chk(n_clr == 1, {tag, " R9 clear pulse count"}, n_clr, 1);
        chk(commit_data == exp_data, {tag, " R8 held data"}, commit_data, exp_data);
        chk(so_oe == 1'b0 && so_data == 1'b0, {tag, " R2 released"}, {so_oe, so_data}, 0);
    endtask

    task automatic run_frame(input logic [15:0] dw, input logic [15:0] fr,
                             input int np);
        bit exp_commit;
        diag_word = dw;
        sclk_pin = 1'b0;
        si_pin = fr[15];
        cs_n_pin = 1'b0;
        wait_cyc(6);
        chk(so_oe == 1'b1, "R2 driven when selected", so_oe, 1);
        chk(so_data == dw[15], "R3 first diag bit", so_data, dw[15]);
        for (int i = 0; i < np; i++) begin
            si_pin = (i < 16) ? fr[15-i] : 1'b0;
            sclk_pin = 1'b1;
            wait_cyc(H);
            if (i < 16) chk(so_data == dw[15-i], "R4 diag bit order", so_data, dw[15-i]);
            sclk_pin = 1'b0;
            wait_cyc(H);
        end
        exp_commit = (np == 16) && (fr[15:8] != 8'h00);   // R5 R6 R7 R10
        if (exp_commit) exp_data = fr[7:0];
        close_frame(exp_commit, "R5 frame");
        wait_cyc(4);
    endtask

    initial begin
        wait_cyc(3);
        chk(so_oe == 0 && so_data == 0, "R1 reset so", {so_oe, so_data}, 0);
        chk(commit_stb == 0 && diag_clear == 0, "R1 reset strobes", {commit_stb, diag_clear}, 0);
        chk(commit_data == 8'h00, "R1 reset data", commit_data, 0);
        rst_n = 1'b1;
        wait_cyc(6);
        chk(commit_stb == 0 && so_oe == 0, "R1 quiet after reset", {commit_stb, so_oe}, 0);

        for (int v = 0; v < NV; v++)
            run_frame(VEC[v][37:22], VEC[v][21:6], int'(VEC[v][5:0]));

        // R11: toggling SCLK and SI with chip-select high does nothing
        begin
            int bad = 0;
            for (int i = 0; i < 20; i++) begin
                si_pin = i[0];
                sclk_pin = ~sclk_pin;
                for (int c = 0; c < H; c++) begin
                    @(negedge clk);
                    if (commit_stb || diag_clear || so_oe) bad++;
                end
            end
            sclk_pin = 1'b0;
            chk(bad == 0, "R11 idle activity ignored", bad, 0);
            chk(commit_data == exp_data, "R11 data unchanged", commit_data, exp_data);
        end

        // R12: reset in the middle of a frame abandons it
        begin
            int n_stb = 0;
            diag_word = 16'h3C3C;
            cs_n_pin = 1'b0;
            wait_cyc(6);
            for (int i = 0; i < 16; i++) begin
                if (i == 10) begin
                    rst_n = 1'b0;
                    wait_cyc(3);
                    rst_n = 1'b1;
                    wait_cyc(4);
                end
                si_pin = 1'b1;
                sclk_pin = 1'b1;
                wait_cyc(H);
                sclk_pin = 1'b0;
                wait_cyc(H);
            end
            cs_n_pin = 1'b1;
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                if (commit_stb) n_stb++;
            end
            chk(n_stb == 0, "R12 no commit after mid-frame reset", n_stb, 0);
            chk(commit_data == 8'h00, "R12 data cleared by reset", commit_data, 0);
            exp_data = 8'h00;
        end

        // R7: a commit after reset with another nonzero control value
        run_frame(16'h9669, 16'h0181, 16);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule